// File: doc/BRIEF.md
# Configurable GPIO Port Controller

An eight-pin general-purpose I/O port with a small synchronous register bus. Software owns three things for each pin. The first is an output latch. The second is a direction bit. The third is a set of pad-control bits: pullup, slew limiting and high drive. The pad-control bits live in their own address region and are independent of the latch and the direction bits. The block drives a pad model with five per-pin signals: output enable, output data, effective pullup, slew enable and high drive.

A shared peripheral can take a pin over through a per-pin override, supplying its own output enable and output data. An analog owner flag per pin keeps the pullup off. Reading the data address returns a mix of two sources: the latch for pins set as outputs, and a two-flop synchronized copy of the pad input for pins set as inputs.

The register bus has no back-pressure and is always ready. A write takes effect at the clock edge where `bus_we` is high. Read data depends only on `bus_addr` and the current state, so no read strobe is needed.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all five pad output vectors are 0.
- R2: The register map is: address 0 is the data latch, 1 is direction, 4 is pullup enable, 5 is slew enable and 6 is high drive. A pin with direction bit 1 and no peripheral override has `pad_oe`=1 and `pad_do` equal to its latch bit. A read of address 1 returns the direction bits.
- R3: A read of address 0 returns, for each pin, the latch bit where the direction bit is 1 and the synchronized pad input where it is 0. Peripheral override does not change this read.
- R4: A change on `pin_in` that is present at clock edge k is visible on the address-0 read of an input pin after edge k+1 and not after edge k.
- R5: Writing the latch while a pin is an input leaves `pad_oe` at 0. When the direction bit is later set, `pad_do` shows the preloaded value in the same cycle that `pad_oe` rises.
- R6: `pad_pu` = pullup bit AND NOT effective output enable AND NOT `analog_sel`. The effective output enable is `periph_oe` when overridden and the direction bit otherwise.
- R7: `pad_slew` = slew bit AND effective output enable.
- R8: `pad_hd` = drive bit AND effective output enable.
- R9: Where `periph_own` is 1, `pad_oe` follows `periph_oe` and `pad_do` follows `periph_do`, whatever the direction bit and latch hold.
- R10: Writes to addresses 0 and 1 leave the pad-control registers unchanged, and writes to addresses 4 to 6 leave the latch and direction unchanged. This is checked by reading back.
- R11: Addresses 2, 3 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| periph_own | input | 8 | Peripheral takes over the pin |
| periph_oe | input | 8 | Peripheral output enable |
| periph_do | input | 8 | Peripheral output data |
| analog_sel | input | 8 | Analog function owns the pin |
| pad_oe | output | 8 | Pad output enable |
| pad_do | output | 8 | Pad output data |
| pad_pu | output | 8 | Effective pullup enable |
| pad_slew | output | 8 | Effective slew limiting |
| pad_hd | output | 8 | Effective high drive |

## Verification
The hardest condition to reach from the ports is a pad edge that is still in flight in the synchronizer while the same pin's direction bit is flipped. In that case the read source changes between the latch and a stale synchronized value. Random cycles mix direction writes with `pin_in` changes on every cycle. A bench model shifts its own two-stage copy of the pins and predicts the read each cycle. Directed steps separately pin the exact edge of the two-cycle latency and the preload-then-enable sequence.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_DIR   = 3'd1,
    A_PULL  = 3'd4,
    A_SLEW  = 3'd5,
    A_DRIVE = 3'd6
  } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk
      // R4
      sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (d_out == $past(d_in, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic [WIDTH-1:0]  slew_q,
  output logic [WIDTH-1:0]  drive_q
);
  localparam int NREG = 5;
  localparam logic [ADDR_W-1:0] MAP [NREG] = '{A_DATA, A_DIR, A_PULL, A_SLEW, A_DRIVE};

  logic [WIDTH-1:0] regs [NREG];

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[r] <= '0;
        else if (we && addr == MAP[r]) regs[r] <= wdata;
      end
    end
  endgenerate

  assign latch_q = regs[0];
  assign dir_q   = regs[1];
  assign pull_q  = regs[2];
  assign slew_q  = regs[3];
  assign drive_q = regs[4];

  // R5
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DATA) |=> (latch_q == $past(wdata)));

  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_DIR) |=> $stable(dir_q));

  // R11
  pad_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr[2]) |=> ($stable(pull_q) && $stable(slew_q) && $stable(drive_q)));
endmodule

// File: rtl/gpio_pad_gate.sv
module gpio_pad_gate #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] latch,
  input  logic [WIDTH-1:0] pull,
  input  logic [WIDTH-1:0] slew,
  input  logic [WIDTH-1:0] drive,
  input  logic [WIDTH-1:0] own,
  input  logic [WIDTH-1:0] p_oe,
  input  logic [WIDTH-1:0] p_do,
  input  logic [WIDTH-1:0] analog,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] pu,
  output logic [WIDTH-1:0] sl,
  output logic [WIDTH-1:0] hd
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      logic oe_eff;
      assign oe_eff  = own[i] ? p_oe[i] : dir[i];
      assign oe[i]   = oe_eff;
      assign dout[i] = own[i] ? p_do[i] : latch[i];
      assign pu[i]   = pull[i] & ~oe_eff & ~analog[i];
      assign sl[i]   = slew[i] & oe_eff;
      assign hd[i]   = drive[i] & oe_eff;
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  periph_own,
  input  logic [WIDTH-1:0]  periph_oe,
  input  logic [WIDTH-1:0]  periph_do,
  input  logic [WIDTH-1:0]  analog_sel,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_do,
  output logic [WIDTH-1:0]  pad_pu,
  output logic [WIDTH-1:0]  pad_slew,
  output logic [WIDTH-1:0]  pad_hd
);
  localparam int SYNC_STAGES = 2;

  logic [WIDTH-1:0] latch_q, dir_q, pull_q, slew_q, drive_q, pin_sync;

  gpio_regfile #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q),
    .drive_q(drive_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_out(pin_sync)
  );

  gpio_pad_gate #(.WIDTH(WIDTH)) u_gate (
    .dir(dir_q), .latch(latch_q), .pull(pull_q), .slew(slew_q), .drive(drive_q),
    .own(periph_own), .p_oe(periph_oe), .p_do(periph_do), .analog(analog_sel),
    .oe(pad_oe), .dout(pad_do), .pu(pad_pu), .sl(pad_slew), .hd(pad_hd)
  );

  always_comb begin
    unique case (bus_addr)
      A_DATA:  bus_rdata = (dir_q & latch_q) | (~dir_q & pin_sync);
      A_DIR:   bus_rdata = dir_q;
      A_PULL:  bus_rdata = pull_q;
      A_SLEW:  bus_rdata = slew_q;
      A_DRIVE: bus_rdata = drive_q;
      default: bus_rdata = '0;
    endcase
  end

  // R6
  pu_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & (pad_oe | analog_sel)) == '0));

  // R7
  slew_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_slew & ~pad_oe) == '0));

  // R9
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ periph_oe) & periph_own) == '0));
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic bus_we = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata, pin_in = 0;
  logic [W-1:0] periph_own = 0, periph_oe = 0, periph_do = 0, analog_sel = 0;
  logic [W-1:0] pad_oe, pad_do, pad_pu, pad_slew, pad_hd;

  int checks = 0, errors = 0;
  logic [W-1:0] m_lat = 0, m_dir = 0, m_pu = 0, m_sl = 0, m_ds = 0, m_s1 = 0, m_s2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl u0 (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return (m_dir & m_lat) | (~m_dir & m_s2);
      3'd1: return m_dir;
      3'd4: return m_pu;
      3'd5: return m_sl;
      3'd6: return m_ds;
      default: return '0;
    endcase
  endfunction

  function automatic string read_req(logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1: return "R2";
      3'd4, 3'd5, 3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_pads();
    logic [W-1:0] oe;
    oe = (periph_own & periph_oe) | (~periph_own & m_dir);
    chk("R2/R9 oe", pad_oe, oe);
    chk("R9 do", pad_do, (periph_own & periph_do) | (~periph_own & m_lat));
    chk("R6 pu", pad_pu, m_pu & ~oe & ~analog_sel);
    chk("R7 slew", pad_slew, m_sl & oe);
    chk("R8 hd", pad_hd, m_ds & oe);
  endtask

  // drive inputs at negedge, advance one edge, update model, then check
  task automatic cycle(logic [2:0] a, logic we, logic [W-1:0] wd, logic [W-1:0] pin);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = wd; pin_in = pin;
    @(posedge clk);
    if (we) case (a)
      3'd0: m_lat = wd;
      3'd1: m_dir = wd;
      3'd4: m_pu = wd;
      3'd5: m_sl = wd;
      3'd6: m_ds = wd;
      default: ;
    endcase
    m_s2 = m_s1; m_s1 = pin;
    #1;
    chk(read_req(a), bus_rdata, exp_read(a));
    check_pads();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 3);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      bus_addr = a[2:0]; #1;
      chk("R1 read", bus_rdata, '0);
    end
    chk("R1 pads", pad_oe | pad_do | pad_pu | pad_slew | pad_hd, '0);
    @(negedge clk); rst_n = 1;

    // R4 exact latency, pin is input
    cycle(3'd0, 0, 0, 8'h00);
    cycle(3'd0, 0, 0, 8'h00);
    cycle(3'd0, 0, 0, 8'hA5);
    chk("R4 one edge", bus_rdata, 8'h00);
    cycle(3'd0, 0, 0, 8'hA5);
    chk("R4 two edges", bus_rdata, 8'hA5);

    // R5 preload then enable
    cycle(3'd0, 1, 8'h3C, 8'h00);
    chk("R5 still input", pad_oe, 8'h00);
    cycle(3'd1, 1, 8'hFF, 8'h00);
    chk("R5 oe", pad_oe, 8'hFF);
    chk("R5 do", pad_do, 8'h3C);

    // R10 pad-bank write leaves data/dir; R6 analog kills pullup
    cycle(3'd4, 1, 8'hFF, 8'h00);
    cycle(3'd1, 1, 8'h0F, 8'h00);
    analog_sel = 8'h03;
    cycle(3'd4, 0, 0, 8'h00);
    chk("R6 analog", pad_pu, 8'hF0 & ~8'h03);
    cycle(3'd0, 0, 0, 8'h00);
    chk("R10 latch kept", bus_rdata & 8'h0F, 8'h0C);

    // R11 unmapped write ignored
    cycle(3'd7, 1, 8'hFF, 8'h00);
    cycle(3'd2, 1, 8'hFF, 8'h00);
    cycle(3'd6, 0, 0, 8'h00);
    chk("R11 no effect", bus_rdata, 8'h00);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      @(negedge clk);
      periph_own = 8'($urandom); periph_oe = 8'($urandom);
      periph_do = 8'($urandom); analog_sel = 8'($urandom);
      cycle(a, 1'($urandom_range(0, 2) == 0), 8'($urandom), 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule